// File: doc/BRIEF.md
# Sequential 32-bit Integer Divider

This block computes the quotient or the remainder of two 32-bit integers, signed or unsigned, for the M extension of a pipelined RV32 core. A request carries a dividend, a divisor and a 2-bit operation code. The unit converts signed operands to magnitudes. It then runs a restoring shift-subtract loop that settles one quotient bit per clock. The loop decides each subtraction by an explicit magnitude compare of the partial remainder against the divisor. Once the loop ends, the unit applies the result signs and the architectural rules for a zero divisor and for signed overflow.

The request side behaves like a valid/ready port whose ready is the inverse of `busy`. A request is taken on any clock where `in_valid` is high and `busy` is low. While `busy` is high the unit applies back-pressure, and the request lines are not looked at. The result side has no back-pressure. `out_valid` is high for exactly one cycle, and `out_data` must be captured in that cycle. The pipeline holds its execute stage while `busy` is high.

Every request takes the same time, whatever the operands. This includes a zero divisor and the overflow case.

Top module: `seq_divider`

## Requirements
- R1: The op code selects the operation: 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder, 2'b11 unsigned remainder. Unsigned forms return floor(a/b) and a mod b.
- R2: The signed quotient is rounded toward zero. Its sign is negative when the operand signs differ.
- R3: The signed remainder satisfies a = q*b + r, and r takes the sign of the dividend.
- R4: With a zero divisor, the quotient forms return 32'hFFFFFFFF and the remainder forms return the dividend unchanged. This holds for both the signed and the unsigned forms.
- R5: A signed request with 32'h80000000 as dividend and 32'hFFFFFFFF as divisor returns 32'h80000000 as quotient and 0 as remainder. The unsigned forms treat the same operands as ordinary numbers.
- R6: A request is accepted on a clock where `in_valid` is high and `busy` is low. `busy` is high from the next cycle on.
- R7: If a request is accepted in cycle t, `out_valid` is high in cycle t+33 only, with the result on `out_data`. `busy` is high in cycles t+1 to t+33 and low in cycle t+34.
- R8: `in_valid` and the operand lines are ignored while `busy` is high. The pending result is unchanged and no extra result is produced.
- R9: With `in_valid` held high, a new request is accepted in the cycle right after `out_valid`, which gives one result every 34 cycles.
- R10: During and straight after reset, `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, taken when `busy` is low |
| in_a | input | 32 | Dividend |
| in_b | input | 32 | Divisor |
| in_op | input | 2 | Operation code (see R1) |
| busy | output | 1 | Operation in progress; inverse of request ready |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 32 | Quotient or remainder, valid with `out_valid` |

## Verification
The hardest condition to reach from the ports is a request that arrives while a divide is still running. It must leave both the pending result and the result timing untouched. The stimulus creates this by holding `in_valid` high with different operands for several cycles in the middle of a running divide. It also holds `in_valid` high across whole operations, which drives the exact cycle where one result leaves and the next request enters. Operands near the sign boundary, a zero divisor and the most-negative dividend over minus one are applied directly, because random operands would almost never hit them.

// File: rtl/div_pkg.sv
package div_pkg;

  // Low two bits of the M-extension funct3 for the divide group
  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } div_state_e;

  // Per-request context carried from operand preparation to result fix-up
  typedef struct packed {
    logic want_rem;
    logic neg_q;
    logic neg_r;
    logic by_zero;
    logic ovf;
  } div_ctx_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output div_ctx_t     ctx
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic is_signed;
  logic neg_a;
  logic neg_b;

  always_comb begin
    is_signed = ~op[0];
    neg_a     = is_signed & a[W-1];
    neg_b     = is_signed & b[W-1];
    mag_a     = neg_a ? (~a + 1'b1) : a;
    mag_b     = neg_b ? (~b + 1'b1) : b;

    ctx.want_rem = op[1];
    ctx.neg_q    = neg_a ^ neg_b;
    ctx.neg_r    = neg_a;
    ctx.by_zero  = (b == '0);
    ctx.ovf      = is_signed & (a == MOST_NEG) & (b == '1);
  end

endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic         take;
  logic [W-1:0] diff;

  always_comb begin
    // bring the next dividend bit into the partial remainder
    shifted = {rem_i, quo_i[W-1]};
    // explicit magnitude compare decides the subtraction
    take    = (shifted >= {1'b0, dvs_i});
    // when take is set the true difference is below 2**W
    diff    = shifted[W-1:0] - dvs_i;
    rem_o   = take ? diff : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], take};
  end

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic [W-1:0] raw_a,
  input  div_ctx_t     ctx,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] quo_s;
  logic [W-1:0] rem_s;

  always_comb begin
    quo_s = ctx.neg_q ? (~quo_mag + 1'b1) : quo_mag;
    rem_s = ctx.neg_r ? (~rem_mag + 1'b1) : rem_mag;
    if (ctx.by_zero) begin
      result = ctx.want_rem ? raw_a : '1;
    end else if (ctx.ovf) begin
      result = ctx.want_rem ? '0 : MOST_NEG;
    end else begin
      result = ctx.want_rem ? rem_s : quo_s;
    end
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [1:0]   in_op,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  div_state_e   state;
  logic [CW-1:0] step_cnt;
  logic [W-1:0] rem_r;
  logic [W-1:0] quo_r;
  logic [W-1:0] dvs_r;
  logic [W-1:0] raw_a_r;
  div_ctx_t     ctx_r;
  logic [W-1:0] res_r;

  logic [W-1:0] mag_a;
  logic [W-1:0] mag_b;
  div_ctx_t     ctx_in;
  logic [W-1:0] rem_nx;
  logic [W-1:0] quo_nx;
  logic [W-1:0] fixed;
  logic         accept;

  div_operand_prep #(.W(W)) u_prep (
    .a     (in_a),
    .b     (in_b),
    .op    (in_op),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .ctx   (ctx_in)
  );

  div_step #(.W(W)) u_step (
    .rem_i (rem_r),
    .quo_i (quo_r),
    .dvs_i (dvs_r),
    .rem_o (rem_nx),
    .quo_o (quo_nx)
  );

  div_result_fix #(.W(W)) u_fix (
    .quo_mag (quo_nx),
    .rem_mag (rem_nx),
    .raw_a   (raw_a_r),
    .ctx     (ctx_r),
    .result  (fixed)
  );

  assign accept = in_valid & (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      rem_r    <= '0;
      quo_r    <= '0;
      dvs_r    <= '0;
      raw_a_r  <= '0;
      ctx_r    <= '0;
      res_r    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_RUN;
            step_cnt <= '0;
            rem_r    <= '0;
            quo_r    <= mag_a;
            dvs_r    <= mag_b;
            raw_a_r  <= in_a;
            ctx_r    <= ctx_in;
          end
        end
        ST_RUN: begin
          rem_r    <= rem_nx;
          quo_r    <= quo_nx;
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST_STEP) begin
            state <= ST_FIN;
            res_r <= fixed;
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign out_valid = (state == ST_FIN);
  assign out_data  = res_r;

endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [1:0]   in_op,
  input logic         busy,
  input logic         out_valid,
  input logic [W-1:0] out_data
);
  localparam int LAT = W + 1;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  int   lat_cnt;
  logic zero_q;
  logic ovf_q;
  logic ovf_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= 0;
      zero_q  <= 1'b0;
      ovf_q   <= 1'b0;
      ovf_r   <= 1'b0;
    end else if (in_valid && !busy) begin
      lat_cnt <= 1;
      zero_q  <= (in_b == '0) && !in_op[1];
      ovf_q   <= (in_a == MOST_NEG) && (in_b == '1) && (in_op == 2'b00);
      ovf_r   <= (in_a == MOST_NEG) && (in_b == '1) && (in_op == 2'b10);
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);  // R6
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lat_cnt == LAT));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);  // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !busy);  // R7
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(out_valid));  // R8
  AST_ZERO_QUOT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zero_q) |-> (out_data == '1));  // R4
  AST_OVF_QUOT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ovf_q) |-> (out_data == MOST_NEG));  // R5
  AST_OVF_REM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ovf_r) |-> (out_data == '0));  // R5

endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_op     (in_op),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/seq_divider_test.sv
module seq_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [1:0]  in_op = '0;
  logic        busy;
  logic        out_valid;
  logic [31:0] out_data;

  string       cur_tag = "R1";
  int          checks = 0;
  int          fails = 0;
  bit          ena = 1'b0;
  bit          done_flag = 1'b0;

  int          m_cnt = 0;
  logic [31:0] m_res = '0;
  string       m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_divider uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_op(in_op), .busy(busy), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] ref_div(logic [31:0] a, logic [31:0] b, logic [1:0] op);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    case (op)
      2'b01: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      2'b11: return (b == 0) ? a : a % b;
      2'b00: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return 32'(sa / sb);
      end
      default: begin
        if (b == 0) return a;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
        return 32'(sa % sb);
      end
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] op);
    if (op[0]) return "R1";
    return op[1] ? "R3" : "R2";
  endfunction

  // behavioural reference: a cycle counter since acceptance
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0;
    end else if (m_cnt == 0) begin
      if (in_valid) begin
        m_cnt = 1;
        m_res = ref_div(in_a, in_b, in_op);
        m_tag = cur_tag;
      end
    end else begin
      m_cnt = (m_cnt == LAT) ? 0 : m_cnt + 1;
    end
  end

  task automatic check1(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (ena && !done_flag) begin
      if (rst) begin
        check1("R10", "busy in reset", 32'(busy), 32'(0));
        check1("R10", "out_valid in reset", 32'(out_valid), 32'(0));
      end else begin
        check1("R6", "busy", 32'(busy), 32'(m_cnt != 0));
        check1("R7", "out_valid", 32'(out_valid), 32'(m_cnt == LAT));
        if (m_cnt == LAT) check1(m_tag, "result", out_data, m_res);
      end
    end
  end

  task automatic issue(logic [31:0] a, logic [31:0] b, logic [1:0] op, string tag);
    while (busy) @(negedge clk);
    in_a = a; in_b = b; in_op = op; cur_tag = tag; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(posedge clk);
    ena = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 unsigned forms
    issue(32'd100, 32'd7, 2'b01, "R1");
    issue(32'd100, 32'd7, 2'b11, "R1");
    issue(32'hFFFF_FFFF, 32'd1, 2'b01, "R1");
    issue(32'd5, 32'hFFFF_FFFF, 2'b11, "R1");
    issue(32'hFFFF_FFFE, 32'hFFFF_FFFF, 2'b01, "R1");
    // R2 signed quotient rounding and signs
    issue(-32'sd7, 32'd2, 2'b00, "R2");
    issue(32'd7, -32'sd2, 2'b00, "R2");
    issue(-32'sd7, -32'sd2, 2'b00, "R2");
    issue(32'h8000_0000, 32'd2, 2'b00, "R2");
    // R3 signed remainder sign
    issue(-32'sd7, 32'd2, 2'b10, "R3");
    issue(32'd7, -32'sd2, 2'b10, "R3");
    issue(-32'sd7, -32'sd2, 2'b10, "R3");
    // R4 zero divisor, all four forms
    issue(32'h1234_5678, 32'd0, 2'b00, "R4");
    issue(32'h8765_4321, 32'd0, 2'b01, "R4");
    issue(32'h8765_4321, 32'd0, 2'b10, "R4");
    issue(32'h1234_5678, 32'd0, 2'b11, "R4");
    // R5 signed overflow and the unsigned view of the same operands
    issue(32'h8000_0000, 32'hFFFF_FFFF, 2'b00, "R5");
    issue(32'h8000_0000, 32'hFFFF_FFFF, 2'b10, "R5");
    issue(32'h8000_0000, 32'hFFFF_FFFF, 2'b01, "R5");
    issue(32'h8000_0000, 32'hFFFF_FFFF, 2'b11, "R5");
    // random patterns
    for (int i = 0; i < 24; i++) begin
      logic [31:0] ra, rb;
      logic [1:0]  ro;
      ra = $urandom;
      rb = (i % 3 == 0) ? ($urandom & 32'hFF) : $urandom;
      ro = 2'($urandom);
      issue(ra, rb, ro, tag_of(ro));
    end
    // R8 stray requests during a running divide
    issue(32'd1000, 32'd9, 2'b00, "R8");
    repeat (4) @(negedge clk);
    in_a = 32'hDEAD_BEEF; in_b = 32'd3; in_op = 2'b11; in_valid = 1'b1;
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    drain();
    // R9 request held high across consecutive operations
    while (busy) @(negedge clk);
    in_a = 32'hCAFE_0001; in_b = 32'd77; in_op = 2'b01; cur_tag = "R9"; in_valid = 1'b1;
    repeat (3 * (LAT + 1) + 2) @(negedge clk);
    in_valid = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule